// File: doc/BRIEF.md
# Bidirectional Interprocessor Mailbox Pair

This block holds a pair of 32-bit message registers that let a host processor and a signal processor exchange words, one register per direction. Each register has a high half and a low half of 16 bits. The top bit of the high half is the "message waiting" flag. A sender first writes the high half and then the low half. Writing the low half commits the message and raises the flag. The receiver reads the high half and then the low half. Asserting the low-half read strobe consumes the message and drops the flag.

Each mailbox has separate write strobes and data for its two halves, a read strobe for its low half, combinational read data for both halves, a 32-bit peek word and a pending output. The peek word has no side effect. The pending output carries the flag so that it can drive an interrupt request. Mailbox ports are packed, with mailbox m at slice m of each vector. All state updates on the rising clock edge. The active-high reset is synchronous.

Top module: `ipc_mailbox_pair`

## Requirements
- R1: When reset is applied, every half of every mailbox reads zero and every pending output is low.
- R2: A high-half write stores bits 14:0 of the written value and forces bit 15 (the flag) to zero, if no low-half write to the same mailbox happens in that cycle.
- R3: A low-half write stores all 16 bits and sets bit 15 of that mailbox's high half on the same clock edge.
- R4: The low-half read data shows the stored low value. Asserting the low-half read strobe clears the flag at the next edge, unless a low-half write to that mailbox happens in the same cycle.
- R5: The high-half read data shows all 16 stored bits, including the flag. Reading it has no effect on any state.
- R6: The peek output for mailbox m is {high, low}. Observing it never changes the flag or the data.
- R7: When a low-half read strobe and a low-half write hit the same mailbox in one cycle, the write wins. The low half takes the new value and the flag ends set.
- R8: When a high-half write and a low-half write hit the same mailbox in one cycle, both halves take their new data and the flag ends set.
- R9: pending[m] always equals bit 15 of mailbox m's high half.
- R10: A strobe aimed at one mailbox never changes the other mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_hi_en | input | 2 | High-half write strobe per mailbox |
| wr_hi_data | input | 32 | High-half write data, 16 bits per mailbox |
| wr_lo_en | input | 2 | Low-half write strobe per mailbox (commits the message) |
| wr_lo_data | input | 32 | Low-half write data, 16 bits per mailbox |
| rd_lo_en | input | 2 | Low-half read strobe per mailbox (consumes the message) |
| rd_hi_data | output | 32 | High half of each mailbox, flag included |
| rd_lo_data | output | 32 | Low half of each mailbox |
| peek_data | output | 64 | {high, low} for each mailbox, 32 bits each |
| pending | output | 2 | Message-waiting flag per mailbox |

## Verification
The bench walks all 64 combinations of the three strobes across both mailboxes. It runs the walk twice, with different data. Each mailbox therefore sees every mix of high write, low write and low read, while the other mailbox is idle or busy, and the results are compared with a model. Single-strobe patterns separate flag clearing by a high-half write from flag clearing by a read. The simultaneous patterns confirm that a low write beats both clearing sources. Patterns where only the opposite mailbox is active show that the two mailboxes do not interfere. Idle cycles, and a reset after the sweep, confirm that peeking is passive and that reset clears everything.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBX_HALF_W = 16;
    localparam int MBX_COUNT  = 2;
    localparam int MBX_FLAG   = MBX_HALF_W - 1;
    localparam logic [MBX_HALF_W-1:0] MBX_FLAG_MASK = MBX_HALF_W'(1) << MBX_FLAG;

    typedef logic [MBX_HALF_W-1:0] half_t;

    typedef struct packed {
        half_t hi;
        half_t lo;
    } mbox_t;

    typedef struct packed {
        logic  wr_hi;
        logic  wr_lo;
        logic  rd_lo;
        half_t hi_data;
        half_t lo_data;
    } mbox_req_t;

    // Replace the flag bit of a high half with a new flag value.
    function automatic half_t put_flag(half_t v, logic f);
        return (v & ~MBX_FLAG_MASK) | (f ? MBX_FLAG_MASK : '0);
    endfunction

endpackage

// File: rtl/mbx_flag_next.sv
module mbx_flag_next (
    input  logic cur,
    input  logic set_msg,
    input  logic clr_hi_wr,
    input  logic clr_rd,
    output logic nxt
);
    // A committed message has priority over both clearing sources.
    always_comb begin
        if (set_msg)
            nxt = 1'b1;
        else if (clr_hi_wr || clr_rd)
            nxt = 1'b0;
        else
            nxt = cur;
    end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
    import mbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  mbox_req_t req,
    output mbox_t     state
);
    mbox_t cur_q;
    logic  flag_d;
    half_t hi_base;

    mbx_flag_next flag_i (
        .cur       (cur_q.hi[MBX_FLAG]),
        .set_msg   (req.wr_lo),
        .clr_hi_wr (req.wr_hi),
        .clr_rd    (req.rd_lo),
        .nxt       (flag_d)
    );

    assign hi_base = req.wr_hi ? req.hi_data : cur_q.hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q.hi <= put_flag(hi_base, flag_d);
            if (req.wr_lo)
                cur_q.lo <= req.lo_data;
        end
    end

    assign state = cur_q;

    AST_LO_WRITE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        req.wr_lo |=> cur_q.hi[MBX_FLAG]);                                      // R3
    AST_LO_WRITE_DATA: assert property (@(posedge clk) disable iff (rst)
        req.wr_lo |=> cur_q.lo == $past(req.lo_data));                          // R3
    AST_HI_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (req.wr_hi && !req.wr_lo) |=> !cur_q.hi[MBX_FLAG]);                     // R2
    AST_HI_WRITE_BITS: assert property (@(posedge clk) disable iff (rst)
        req.wr_hi |=> cur_q.hi[MBX_FLAG-1:0] == $past(req.hi_data[MBX_FLAG-1:0])); // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (req.rd_lo && !req.wr_lo) |=> !cur_q.hi[MBX_FLAG]);                     // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!req.wr_lo && !req.wr_hi && !req.rd_lo) |=> $stable(cur_q));           // R6
    AST_LO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req.wr_lo |=> $stable(cur_q.lo));                                      // R4
endmodule

// File: rtl/ipc_mailbox_pair.sv
module ipc_mailbox_pair
    import mbx_pkg::*;
#(
    parameter int NUM_MBOX = MBX_COUNT
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_MBOX-1:0]              wr_hi_en,
    input  logic [NUM_MBOX*MBX_HALF_W-1:0]   wr_hi_data,
    input  logic [NUM_MBOX-1:0]              wr_lo_en,
    input  logic [NUM_MBOX*MBX_HALF_W-1:0]   wr_lo_data,
    input  logic [NUM_MBOX-1:0]              rd_lo_en,
    output logic [NUM_MBOX*MBX_HALF_W-1:0]   rd_hi_data,
    output logic [NUM_MBOX*MBX_HALF_W-1:0]   rd_lo_data,
    output logic [NUM_MBOX*2*MBX_HALF_W-1:0] peek_data,
    output logic [NUM_MBOX-1:0]              pending
);
    localparam int WORD_W = 2 * MBX_HALF_W;

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
        mbox_req_t req;
        mbox_t     st;

        assign req.wr_hi   = wr_hi_en[m];
        assign req.wr_lo   = wr_lo_en[m];
        assign req.rd_lo   = rd_lo_en[m];
        assign req.hi_data = wr_hi_data[m*MBX_HALF_W +: MBX_HALF_W];
        assign req.lo_data = wr_lo_data[m*MBX_HALF_W +: MBX_HALF_W];

        mbx_slot slot_i (
            .clk   (clk),
            .rst   (rst),
            .req   (req),
            .state (st)
        );

        assign rd_hi_data[m*MBX_HALF_W +: MBX_HALF_W] = st.hi;
        assign rd_lo_data[m*MBX_HALF_W +: MBX_HALF_W] = st.lo;
        assign peek_data[m*WORD_W +: WORD_W]          = {st.hi, st.lo};
        assign pending[m]                             = st.hi[MBX_FLAG];

        AST_PENDING_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
            wr_lo_en[m] |=> pending[m]);                                         // R9
        AST_PEEK_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
            (!wr_lo_en[m] && !wr_hi_en[m] && !rd_lo_en[m]) |=> $stable(peek_data[m*WORD_W +: WORD_W])); // R10
    end
endmodule

// File: tb/ipc_mailbox_pair_tb_top.sv
`timescale 1ns/1ps
module ipc_mailbox_pair_tb_top;
    localparam int N = 2;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0]     wr_hi_en, wr_lo_en, rd_lo_en;
    logic [N*W-1:0]   wr_hi_data, wr_lo_data;
    logic [N*W-1:0]   rd_hi_data, rd_lo_data;
    logic [N*2*W-1:0] peek_data;
    logic [N-1:0]     pending;

    int vectors = 0;
    int fails   = 0;
    logic [15:0] m_hi [N];
    logic [15:0] m_lo [N];

    always #4 clk = ~clk;

    ipc_mailbox_pair dut_i (
        .clk(clk), .rst(rst),
        .wr_hi_en(wr_hi_en), .wr_hi_data(wr_hi_data),
        .wr_lo_en(wr_lo_en), .wr_lo_data(wr_lo_data),
        .rd_lo_en(rd_lo_en),
        .rd_hi_data(rd_hi_data), .rd_lo_data(rd_lo_data),
        .peek_data(peek_data), .pending(pending)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_state(string req);
        for (int m = 0; m < N; m++) begin
            check(req, peek_data[m*2*W +: 2*W], {m_hi[m], m_lo[m]});        // R6
            check({req, "/R9"}, 32'(pending[m]), 32'(m_hi[m][15]));          // R9
            check({req, "/R5"}, 32'(rd_hi_data[m*W +: W]), 32'(m_hi[m]));    // R5
        end
    endtask

    task automatic idle_inputs();
        wr_hi_en = '0; wr_lo_en = '0; rd_lo_en = '0;
        wr_hi_data = '0; wr_lo_data = '0;
    endtask

    function automatic string tag_for(logic whi, logic wlo, logic rlo, logic other);
        if (wlo && rlo) return "R7";
        if (wlo && whi) return "R8";
        if (wlo)        return "R3";
        if (rlo)        return "R4";
        if (whi)        return "R2";
        if (other)      return "R10";
        return "R6";
    endfunction

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int m = 0; m < N; m++) begin m_hi[m] = '0; m_lo[m] = '0; end
        check_state("R1");

        for (int k = 0; k < 2; k++) begin
            for (int c = 0; c < 64; c++) begin
                logic [N-1:0] whi, wlo, rlo;
                logic [15:0]  dh [N];
                logic [15:0]  dl [N];
                string        tg [N];
                for (int m = 0; m < N; m++) begin
                    whi[m] = c[m*3];
                    wlo[m] = c[m*3+1];
                    rlo[m] = c[m*3+2];
                    dh[m]  = 16'((c * 16'h0313 + m * 16'h5A5A + k * 16'h2B07) ^ (c[0] ? 16'h8000 : 16'h0));
                    dl[m]  = 16'(c * 16'h1F3D + m * 16'h0777 + k * 16'h4321 + 1);
                end
                @(negedge clk);
                wr_hi_en = whi; wr_lo_en = wlo; rd_lo_en = rlo;
                for (int m = 0; m < N; m++) begin
                    wr_hi_data[m*W +: W] = dh[m];
                    wr_lo_data[m*W +: W] = dl[m];
                end
                #1;
                for (int m = 0; m < N; m++)
                    check("R4", 32'(rd_lo_data[m*W +: W]), 32'(m_lo[m]));   // R4 read data before edge
                @(posedge clk);
                for (int m = 0; m < N; m++) begin
                    logic f;
                    f = m_hi[m][15];
                    if (wlo[m]) m_lo[m] = dl[m];
                    if (whi[m]) m_hi[m][14:0] = dh[m][14:0];
                    if (wlo[m]) f = 1'b1;
                    else if (whi[m] || rlo[m]) f = 1'b0;
                    m_hi[m][15] = f;
                    tg[m] = tag_for(whi[m], wlo[m], rlo[m], (whi[1-m] | wlo[1-m] | rlo[1-m]));
                end
                @(negedge clk);
                idle_inputs();
                #1;
                for (int m = 0; m < N; m++) begin
                    check(tg[m], peek_data[m*2*W +: 2*W], {m_hi[m], m_lo[m]});
                    check({tg[m], "/R9"}, 32'(pending[m]), 32'(m_hi[m][15]));
                end
            end
        end

        // Passive observation over idle cycles (R6, R5).
        repeat (3) begin
            @(negedge clk);
            #1;
            check_state("R6");
        end

        // Reset after activity (R1).
        @(negedge clk);
        wr_lo_en = 2'b11; wr_lo_data = 32'hA5A5_5A5A;
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int m = 0; m < N; m++) begin m_hi[m] = '0; m_lo[m] = '0; end
        #1;
        check_state("R1");
        check("R1", 32'(rd_lo_data), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule